// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port with Output Toggle

This block is one parameterised general-purpose I/O port, eight pins wide by default, for a small microcontroller bus. Each pin has three control bits, each at its own register address: a direction bit, an output latch bit and an input-sample bit. A separate bus decoder supplies write strobes, read strobes and a data bus. The port drives per-pin output-enable, output-level and pull-up-enable signals toward the pads. It passes the pad input levels through a two-flop synchronizer so they can be read back.

The output latch bit has two uses. It sets the driven level when the pin is an output, and it enables the pull-up when the pin is an input. Writing ones at the input-sample address inverts the matching latch bits. A single bus write can therefore flip any set of pins without a read-modify-write. Two inputs are shared by every port: a pull-up kill and a sleep signal. Sleep gates the input path so that the synchronizer settles to zero.

Top module: `gpio_port`

## Requirements
- R1: Reset (rst_ni low) clears the direction bits, output latch bits and synchronizer at once, without waiting for a clock. While reset is held, pad_oe_o, pad_out_o and pad_pu_o are all zero.
- R2: A cycle with wr_dir_i high loads wdata_i into the direction bits on the next rising clk_i edge. Bit n of pad_oe_o equals direction bit n, where 1 means output. The bits hold while wr_dir_i is low.
- R3: A cycle with wr_out_i high loads wdata_i into the output latch on the next edge. For an output pin, pad_out_o bit n equals latch bit n.
- R4: pad_pu_o bit n is 1 only when direction bit n is 0, latch bit n is 1 and pud_i is 0. A pin that is an output never has its pull-up enabled.
- R5: While pud_i is high, every bit of pad_pu_o is 0, whatever the register bits hold.
- R6: A cycle with wr_tgl_i high and wr_out_i low inverts every latch bit whose wdata_i bit is 1, on the next edge, for input and output pins alike. Latch bits whose wdata_i bit is 0 are unchanged.
- R7: When wr_out_i and wr_tgl_i are both high in one cycle, the latch takes wdata_i exactly and no toggle is applied.
- R8: With rd_pin_i high, rdata_o returns the pad_in_i value sampled two rising edges earlier, through the two-flop synchronizer.
- R9: While sleep_i is high, zero enters the synchronizer in place of pad_in_i. Two edges into sleep, a pin read returns 0. Sleep does not change pad_oe_o, pad_out_o or pad_pu_o.
- R10: rd_dir_i returns the direction bits and rd_out_i returns the latch bits. Read strobes that are high together are ORed, and rdata_o is 0 when no read strobe is high. Reads change no state.
- R11: pad_out_o bit n is 0 whenever direction bit n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdata_i | input | WIDTH | Write data bus |
| wr_dir_i | input | 1 | Write strobe, direction register |
| wr_out_i | input | 1 | Write strobe, output latch register |
| wr_tgl_i | input | 1 | Write strobe, input-sample address (toggles latch) |
| rd_dir_i | input | 1 | Read strobe, direction register |
| rd_out_i | input | 1 | Read strobe, output latch register |
| rd_pin_i | input | 1 | Read strobe, synchronized pad levels |
| rdata_o | output | WIDTH | Read data |
| pud_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep, gates the input path |
| pad_in_i | input | WIDTH | Pad input levels |
| pad_oe_o | output | WIDTH | Per-pin output enable |
| pad_out_o | output | WIDTH | Per-pin driven level |
| pad_pu_o | output | WIDTH | Per-pin pull-up enable |

## Verification
A latch load and a toggle can fall in the same cycle. Directed writes provoke this with overlapping bit patterns, so that an applied toggle would visibly differ from the plain load. The result is judged on rd_out_i and pad_out_o on the following cycle. A long stretch of random strobes also fires both writes together along with reads, sleep and pull-up kill. There, a behavioural model of the latch, direction bits and synchronizer queue is compared with every output on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic dir;
    logic port;
    logic tgl;
  } wr_sel_t;

  typedef struct packed {
    logic dir;
    logic port;
    logic pin;
  } rd_sel_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_sel_t          wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] port_o
);
  logic [WIDTH-1:0] dir_q, port_q, port_d;

  // plain load wins over toggle
  always_comb begin
    port_d = port_q;
    if (wr_i.port)     port_d = wdata_i;
    else if (wr_i.tgl) port_d = port_q ^ wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      port_q <= '0;
    end else begin
      if (wr_i.dir) dir_q <= wdata_i;
      port_q <= port_d;
    end
  end

  assign dir_o  = dir_q;
  assign port_o = port_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             gated;

  assign gated = sleep_i ? '0 : d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= gated;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             pud_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] port_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pu_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    assign oe_o[n]  = dir_i[n];
    assign out_o[n] = dir_i[n] & port_i[n];
    assign pu_o[n]  = ~dir_i[n] & port_i[n] & ~pud_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wr_dir_i,
  input  logic             wr_out_i,
  input  logic             wr_tgl_i,
  input  logic             rd_dir_i,
  input  logic             rd_out_i,
  input  logic             rd_pin_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             pud_i,
  input  logic             sleep_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o
);
  wr_sel_t          wr_sel;
  rd_sel_t          rd_sel;
  logic [WIDTH-1:0] dir_q, port_q, pin_sync;

  assign wr_sel = '{dir: wr_dir_i, port: wr_out_i, tgl: wr_tgl_i};
  assign rd_sel = '{dir: rd_dir_i, port: rd_out_i, pin: rd_pin_i};

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel),
    .wdata_i (wdata_i),
    .dir_o   (dir_q),
    .port_o  (port_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_i (sleep_i),
    .d_i     (pad_in_i),
    .q_o     (pin_sync)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .pud_i  (pud_i),
    .dir_i  (dir_q),
    .port_i (port_q),
    .oe_o   (pad_oe_o),
    .out_o  (pad_out_o),
    .pu_o   (pad_pu_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_sel.dir)  rdata_o |= dir_q;
    if (rd_sel.port) rdata_o |= port_q;
    if (rd_sel.pin)  rdata_o |= pin_sync;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wdata_i,
  input logic             wr_dir_i,
  input logic             wr_out_i,
  input logic             wr_tgl_i,
  input logic             rd_dir_i,
  input logic             rd_out_i,
  input logic             rd_pin_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             pud_i,
  input logic             sleep_i,
  input logic [WIDTH-1:0] pad_in_i,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_pu_o,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] port_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  always @(negedge clk_i) begin
    if (rst_ni === 1'b0) begin
      reset_quiet_chk: assert ((pad_oe_o | pad_out_o | pad_pu_o) == '0);
    end
  end

  // R2
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> pad_oe_o == $past(wdata_i));

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(pad_oe_o));

  // R6
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tgl_i && !wr_out_i) |=> port_q == ($past(port_q) ^ $past(wdata_i)));

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out_i |=> port_q == $past(wdata_i));

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_out_i && !wr_tgl_i) |=> $stable(port_q));

  // R4
  no_pu_on_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);

  // R5
  pud_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> pad_pu_o == '0);

  // R11
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  // R8
  pin_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && rd_pin_i && !rd_dir_i && !rd_out_i
     && !$past(sleep_i) && !$past(sleep_i, 2))
    |-> rdata_o == $past(pad_in_i, 2));

  // R9
  sleep_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && rd_pin_i && !rd_dir_i && !rd_out_i
     && $past(sleep_i) && $past(sleep_i, 2)) |-> rdata_o == '0);

  // R10
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_dir_i && !rd_out_i && !rd_pin_i) |-> rdata_o == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic         wr_dir_i = 0, wr_out_i = 0, wr_tgl_i = 0;
  logic         rd_dir_i = 0, rd_out_i = 0, rd_pin_i = 0;
  logic [W-1:0] rdata_o;
  logic         pud_i = 0, sleep_i = 0;
  logic [W-1:0] pad_in_i = '0;
  logic [W-1:0] pad_oe_o, pad_out_o, pad_pu_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] m_dir = '0, m_port = '0;
  logic [W-1:0] m_sync[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_port #(.WIDTH(W)) u0 (.*);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_rdata();
    logic [W-1:0] r = '0;
    if (rd_dir_i) r |= m_dir;
    if (rd_out_i) r |= m_port;
    if (rd_pin_i) r |= m_sync[1];
    return r;
  endfunction

  task automatic model_reset();
    m_dir = '0; m_port = '0;
    m_sync = '{'0, '0};
  endtask

  task automatic compare_all(string ctx);
    chk({ctx, " R2 oe"}, pad_oe_o, m_dir);
    chk({ctx, " R3/R11 out"}, pad_out_o, m_port & m_dir);
    chk({ctx, " R4/R5 pu"}, pad_pu_o, ~m_dir & m_port & {W{~pud_i}});
    chk({ctx, " R10 rdata"}, rdata_o, exp_rdata());
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic cycle(string ctx);
    @(posedge clk_i);
    if (!rst_ni) model_reset();
    else begin
      if (wr_dir_i) m_dir = wdata_i;
      if (wr_out_i) m_port = wdata_i;
      else if (wr_tgl_i) m_port = m_port ^ wdata_i;
      void'(m_sync.pop_back());
      m_sync.push_front(sleep_i ? '0 : pad_in_i);
    end
    @(negedge clk_i);
    compare_all(ctx);
  endtask

  task automatic idle();
    wr_dir_i = 0; wr_out_i = 0; wr_tgl_i = 0;
    rd_dir_i = 0; rd_out_i = 0; rd_pin_i = 0;
  endtask

  task automatic wr(logic d, logic o, logic t, logic [W-1:0] v, string ctx);
    wr_dir_i = d; wr_out_i = o; wr_tgl_i = t; wdata_i = v;
    cycle(ctx);
    idle();
  endtask

  task automatic rd(logic d, logic o, logic p, logic [W-1:0] exp, string tag);
    rd_dir_i = d; rd_out_i = o; rd_pin_i = p;
    #1;
    chk(tag, rdata_o, exp);
    idle();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 state while held in reset
    chk("R1 oe in reset", pad_oe_o, '0);
    chk("R1 pu in reset", pad_pu_o, '0);
    rst_ni = 1'b1;
    cycle("R1 after release");
    rd(1, 0, 0, '0, "R1 dir read after reset");
    rd(0, 1, 0, '0, "R1 latch read after reset");

    // R2 R3 R11 basic configuration
    wr(1, 0, 0, 8'h0F, "R2 dir write");
    rd(1, 0, 0, 8'h0F, "R2 dir readback");
    wr(0, 1, 0, 8'hA5, "R3 latch write");
    rd(0, 1, 0, 8'hA5, "R3 latch readback");
    chk("R3 driven level", pad_out_o, 8'h05);
    chk("R11 inputs not driven", pad_out_o & 8'hF0, '0);
    chk("R4 pull-ups on inputs", pad_pu_o, 8'hA0);

    // R5 pull-up kill
    pud_i = 1; cycle("R5 pud on");
    chk("R5 pull-ups killed", pad_pu_o, '0);
    pud_i = 0; cycle("R5 pud off");
    chk("R5 pull-ups back", pad_pu_o, 8'hA0);

    // R6 toggle on inputs and outputs alike
    wr(0, 0, 1, 8'h81, "R6 toggle");
    rd(0, 1, 0, 8'h24, "R6 toggle result");
    wr(0, 0, 1, 8'h00, "R6 toggle zero");
    rd(0, 1, 0, 8'h24, "R6 toggle zero no change");

    // R7 load and toggle together
    wdata_i = 8'h3C; wr_out_i = 1; wr_tgl_i = 1;
    cycle("R7 collision"); idle();
    rd(0, 1, 0, 8'h3C, "R7 load wins");
    chk("R7 driven level", pad_out_o, 8'h0C);

    // R8 synchronizer latency
    pad_in_i = 8'h5A; rd_pin_i = 1;
    cycle("R8 edge1");
    chk("R8 not yet visible", rdata_o, '0);
    cycle("R8 edge2");
    chk("R8 visible after two edges", rdata_o, 8'h5A);

    // R9 sleep gates input, drive unaffected
    sleep_i = 1;
    cycle("R9 sleep1"); cycle("R9 sleep2");
    chk("R9 pin read zero in sleep", rdata_o, '0);
    chk("R9 drive kept in sleep", pad_oe_o, 8'h0F);
    chk("R9 pull-ups kept in sleep", pad_pu_o, 8'h30);
    sleep_i = 0; idle();

    // R10 OR of simultaneous reads, no strobe gives zero
    cycle("R10 settle"); cycle("R10 settle2");
    rd(1, 1, 0, 8'h3F, "R10 dir|latch");
    rd(0, 0, 0, 8'h00, "R10 no strobe");

    // random traffic, model compared every clock
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      wdata_i = r[7:0]; pad_in_i = r[15:8];
      wr_dir_i = r[16] & r[17]; wr_out_i = r[18] & r[19]; wr_tgl_i = r[20];
      rd_dir_i = r[21]; rd_out_i = r[22]; rd_pin_i = r[23];
      pud_i = r[24] & r[25]; sleep_i = r[26] & r[27] & r[28];
      cycle("rand R6 R7 R8 R9");
    end
    idle(); pud_i = 0; sleep_i = 0;

    // R1 asynchronous reset between edges
    wr(1, 1, 0, 8'hFF, "R1 prep");
    #2 rst_ni = 0;
    #1;
    chk("R1 async oe", pad_oe_o, '0);
    chk("R1 async out", pad_out_o, '0);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1;
    cycle("R1 post");
    rd(1, 1, 1, '0, "R1 all cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule